// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block keeps a 64-bit signed running total in two 32-bit registers, a high word (total bits 63:32) and a low word (total bits 31:0). Each accepted operation multiplies two signed operands and adds the product to the total. A long operation uses the full 32-bit operands. A short operation uses only the low 16 bits of each operand, read as signed values.

A saturation input selects how the sum is written back. With saturation off, the full 64-bit sum wraps in two's complement. With saturation on, the long operation limits the high word. A negative sum has the upper half of the high word forced to ones. A non-negative sum has the high word masked down to its low 15 bits. The short operation clamps the sum to the signed 32-bit range. When it clamps, it writes the marker value 1 into the high word.

A synchronous clear zeroes the total. Two load strobes write either word from a shared data input.

A small controller resolves the strobes of each cycle into one action:
- `ACT_CLEAR` when clear is high.
- `ACT_LOAD` when either load strobe is high.
- `ACT_MAC` when the operation strobe is high.
- `ACT_HOLD` otherwise.

Each edge follows exactly one of these transitions. The priority is clear, then load, then accumulate.

Top module: `mac_sat_unit`

## Requirements
- R1: While `rst_n` is low, both accumulator words become 0 at the next clock edge.
- R2: `clr` high zeroes both words at the edge. It wins over any load or operation strobe in the same cycle.
- R3: `ld_hi` / `ld_lo` write `ld_data` into the high / low word. Both may load in one cycle. A word whose load strobe is low keeps its value. A load cancels an operation issued in the same cycle.
- R4: With `sat_en` low and `op_word` = 0, the full signed 32x32 product is added to the 64-bit total, with 64-bit wraparound.
- R5: With `sat_en` low and `op_word` = 1, only bits 15:0 of each operand are used, as signed values. Bits 31:16 have no effect. The sum wraps at 64 bits.
- R6: With `sat_en` high, `op_word` = 0 and a negative 64-bit sum, the high word bits 31:16 are set to ones. The other bits of the sum are kept.
- R7: With `sat_en` high, `op_word` = 0 and a non-negative sum, the high word becomes (sum bits 63:32) AND 0x00007FFF. The low word holds sum bits 31:0.
- R8: With `sat_en` high and `op_word` = 1, a sum below -2^31 writes high = 1 and low = 0x80000000.
- R9: With `sat_en` high and `op_word` = 1, a sum above 2^31-1 writes high = 1 and low = 0x7FFFFFFF.
- R10: With `sat_en` high and `op_word` = 1, a sum from -2^31 to 2^31-1 inclusive is written back unchanged.
- R11: A result is visible on `acc_hi`/`acc_lo` right after the edge that samples its strobe. With no strobe high, both words hold, whatever `sat_en` and the operands do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero both accumulator words |
| ld_hi | input | 1 | Load high word from ld_data |
| ld_lo | input | 1 | Load low word from ld_data |
| ld_data | input | 32 | Load data |
| op_valid | input | 1 | Operation strobe |
| op_word | input | 1 | 0: 32x32 long operation, 1: 16x16 short operation |
| sat_en | input | 1 | Saturating write-back |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
Every action here lands in the registers at the single edge that samples its strobes. The updated words are therefore due one edge after the bench drives them.

The bench drives inputs on the falling edge and updates its 64-bit reference model at the rising edge. It compares both words one nanosecond after that rising edge, before the next stimulus is applied.

Idle cycles are compared in the same way. This shows that nothing moves without a strobe.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_MAC   = 2'd3
    } acc_act_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic     clr,
    input  logic     ld_hi,
    input  logic     ld_lo,
    input  logic     op_valid,
    output acc_act_e act
);
    always_comb begin
        if (clr)                 act = ACT_CLEAR;
        else if (ld_hi || ld_lo) act = ACT_LOAD;
        else if (op_valid)       act = ACT_MAC;
        else                     act = ACT_HOLD;
    end

    always_comb begin
        if (act == ACT_MAC) assert (!clr && !ld_hi && !ld_lo) else $error("AST_MAC_PRIO"); // R3
    end
endmodule

// File: rtl/mac_product.sv
module mac_product #(
    parameter int DW = 32,
    parameter int HW = 16,
    localparam int AW = 2 * DW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          word_mode,
    output logic [AW-1:0] prod
);
    logic signed [AW-1:0] long_a, long_b, short_a, short_b;
    logic signed [AW-1:0] long_p, short_p;

    always_comb begin
        long_a  = {{(AW-DW){a[DW-1]}}, a};
        long_b  = {{(AW-DW){b[DW-1]}}, b};
        short_a = {{(AW-HW){a[HW-1]}}, a[HW-1:0]};
        short_b = {{(AW-HW){b[HW-1]}}, b[HW-1:0]};
        long_p  = long_a * long_b;
        short_p = short_a * short_b;
        prod    = word_mode ? short_p : long_p;
    end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
    parameter int DW = 32,
    localparam int AW   = 2 * DW,
    localparam int HALF = DW / 2
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] prod,
    input  logic          word_mode,
    input  logic          sat_en,
    output logic [DW-1:0] res_hi,
    output logic [DW-1:0] res_lo
);
    localparam logic [DW-1:0] HI_KEEP  = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
    localparam logic [DW-1:0] HI_FORCE = {{HALF{1'b1}}, {HALF{1'b0}}};
    localparam logic [DW-1:0] MIN_LO   = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_LO   = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MARK     = DW'(1);

    logic [AW-1:0] sum;
    logic          neg_over, pos_over;

    always_comb begin
        sum      = acc + prod;
        neg_over = sum[AW-1] && !(&sum[AW-1:DW-1]);
        pos_over = !sum[AW-1] && (|sum[AW-1:DW-1]);
        res_hi   = sum[AW-1:DW];
        res_lo   = sum[DW-1:0];
        if (sat_en) begin
            if (!word_mode) begin
                if (sum[AW-1]) res_hi = sum[AW-1:DW] | HI_FORCE;
                else           res_hi = sum[AW-1:DW] & HI_KEEP;
            end else if (neg_over) begin
                res_hi = MARK;
                res_lo = MIN_LO;
            end else if (pos_over) begin
                res_hi = MARK;
                res_lo = MAX_LO;
            end
        end
    end

    always_comb begin
        if (sat_en && !word_mode)
            assert ((&res_hi[DW-1:HALF]) || (res_hi[DW-1:HALF-1] == '0)) else $error("AST_LONG_SAT_RANGE"); // R6
        if (sat_en && word_mode)
            assert ((res_hi == {DW{res_lo[DW-1]}}) || (res_hi == MARK)) else $error("AST_WORD_CLAMP_MARK"); // R9
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_data,
    input  logic          op_valid,
    input  logic          op_word,
    input  logic          sat_en,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);
    acc_act_e      act;
    logic [AW-1:0] prod;
    logic [DW-1:0] nxt_hi, nxt_lo;

    mac_ctrl u_ctrl (
        .clr      (clr),
        .ld_hi    (ld_hi),
        .ld_lo    (ld_lo),
        .op_valid (op_valid),
        .act      (act)
    );

    mac_product #(.DW(DW), .HW(HW)) u_prod (
        .a         (op_a),
        .b         (op_b),
        .word_mode (op_word),
        .prod      (prod)
    );

    mac_saturate #(.DW(DW)) u_sat (
        .acc       ({acc_hi, acc_lo}),
        .prod      (prod),
        .word_mode (op_word),
        .sat_en    (sat_en),
        .res_hi    (nxt_hi),
        .res_lo    (nxt_lo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    acc_hi <= '0;
                    acc_lo <= '0;
                end
                ACT_LOAD: begin
                    if (ld_hi) acc_hi <= ld_data;
                    if (ld_lo) acc_lo <= ld_data;
                end
                ACT_MAC: begin
                    acc_hi <= nxt_hi;
                    acc_lo <= nxt_lo;
                end
                ACT_HOLD: ;
                default: ;
            endcase
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (acc_hi == '0 && acc_lo == '0)); // R1
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0)); // R2
    AST_LD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_hi) |=> (acc_hi == $past(ld_data))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_hi && !ld_lo && !op_valid) |=> ($stable(acc_hi) && $stable(acc_lo))); // R11
endmodule

// File: tb/mac_sat_unit_tb.sv
`timescale 1ns/1ps
module mac_sat_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
    logic [31:0] ld_data = '0;
    logic        op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [31:0] acc_hi, acc_lo;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] model = '0;

    always #2.5 clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .ld_data(ld_data), .op_valid(op_valid), .op_word(op_word),
        .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    function automatic logic [63:0] mac_ref(input logic [63:0] acc, input logic [31:0] a,
                                            input logic [31:0] b, input logic w, input logic s);
        logic signed [63:0] pa, pb, sum;
        pa  = w ? {{48{a[15]}}, a[15:0]} : {{32{a[31]}}, a};
        pb  = w ? {{48{b[15]}}, b[15:0]} : {{32{b[31]}}, b};
        sum = $signed(acc) + pa * pb;
        if (s && !w) begin
            if (sum < 0) sum[63:48] = 16'hFFFF;
            else         sum[63:47] = '0;
        end else if (s && w) begin
            if (sum < -64'sd2147483648)     sum = 64'h0000_0001_8000_0000;
            else if (sum > 64'sd2147483647) sum = 64'h0000_0001_7FFF_FFFF;
        end
        return sum;
    endfunction

    function automatic string tag_of(input logic [63:0] acc, input logic [31:0] a,
                                     input logic [31:0] b, input logic w, input logic s);
        logic signed [63:0] pa, pb, sum;
        pa  = w ? {{48{a[15]}}, a[15:0]} : {{32{a[31]}}, a};
        pb  = w ? {{48{b[15]}}, b[15:0]} : {{32{b[31]}}, b};
        sum = $signed(acc) + pa * pb;
        if (!s) return w ? "R5" : "R4";
        if (!w) return (sum < 0) ? "R6" : "R7";
        if (sum < -64'sd2147483648) return "R8";
        if (sum > 64'sd2147483647)  return "R9";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [63:0] exp);
        n_checks++;
        if ({acc_hi, acc_lo} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h_%h expected %h_%h", tag, acc_hi, acc_lo, exp[63:32], exp[31:0]);
        end
    endtask

    // Called at a falling edge; drives, waits the rising edge, updates model, checks.
    task automatic apply(input logic c, input logic lh, input logic ll, input logic [31:0] d,
                         input logic v, input logic w, input logic s,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        string t;
        clr = c; ld_hi = lh; ld_lo = ll; ld_data = d;
        op_valid = v; op_word = w; sat_en = s; op_a = a; op_b = b;
        t = (tag == "") ? tag_of(model, a, b, w, s) : tag;
        @(posedge clk);
        if (c)             model = '0;
        else if (lh || ll) begin
            if (lh) model[63:32] = d;
            if (ll) model[31:0]  = d;
        end
        else if (v)        model = mac_ref(model, a, b, w, s);
        #1;
        check(t, model);
        @(negedge clk);
        clr = 0; ld_hi = 0; ld_lo = 0; op_valid = 0;
    endtask

    task automatic load64(input logic [63:0] v);
        apply(0, 1, 1, v[63:32], 0, 0, 0, 0, 0, "R3");
        apply(0, 0, 1, v[31:0], 0, 0, 0, 0, 0, "R3");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        op_valid = 1; op_a = 32'h1234; op_b = 32'h55;
        repeat (3) @(posedge clk);
        #1; check("R1", 64'd0);
        @(negedge clk); rst_n = 1; op_valid = 0;

        // R4 / R5 basics and upper operand bits ignored
        apply(0, 0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'd5, "R4");
        apply(0, 0, 0, 0, 1, 0, 0, 32'h8000_0000, 32'h8000_0000, "R4");
        apply(0, 0, 0, 0, 1, 1, 0, 32'hABCD_0003, 32'h1234_FFFE, "R5");
        load64(64'h7FFF_FFFF_FFFF_FFFF);
        apply(0, 0, 0, 0, 1, 0, 0, 32'd1, 32'd1, "R4");
        // R11: hold with stray inputs
        apply(0, 0, 0, 0, 0, 1, 1, 32'hFFFF, 32'hFFFF, "R11");
        // R2: clear beats load and op
        apply(1, 1, 1, 32'hDEAD_BEEF, 1, 0, 0, 32'd9, 32'd9, "R2");
        // R3: low load cancels op, high kept
        load64(64'h0000_0010_0000_0020);
        apply(0, 0, 1, 32'h0000_0099, 1, 0, 0, 32'd100, 32'd100, "R3");

        // R6 / R7 long saturation
        load64(64'h0000_0000_0000_0000);
        apply(0, 0, 0, 0, 1, 0, 1, 32'hFFFF_FFFF, 32'd3, "R6");
        load64(64'h1234_5678_0000_0000);
        apply(0, 0, 0, 0, 1, 0, 1, 32'd2, 32'd3, "R7");

        // R8 / R10 lower boundary
        load64(64'hFFFF_FFFF_8000_0000);
        apply(0, 0, 0, 0, 1, 1, 1, 32'd0, 32'd0, "R10");
        apply(0, 0, 0, 0, 1, 1, 1, 32'd1, 32'h0000_FFFF, "R8");
        // R9 / R10 upper boundary
        load64(64'h0000_0000_7FFF_FFFF);
        apply(0, 0, 0, 0, 1, 1, 1, 32'd0, 32'd7, "R10");
        apply(0, 0, 0, 0, 1, 1, 1, 32'd1, 32'd1, "R9");

        // random mix
        for (int i = 0; i < 800; i++) begin
            int k;
            k = $urandom_range(0, 19);
            if (k == 0)
                apply(1, $urandom_range(0, 1), 0, $urandom, $urandom_range(0, 1), 0, 0, $urandom, $urandom, "R2");
            else if (k <= 2)
                apply(0, 1, $urandom_range(0, 1), ($urandom_range(0, 1) ? $urandom : 32'($signed($urandom_range(0, 4)) - 2)),
                      $urandom_range(0, 1), 0, 0, $urandom, $urandom, "R3");
            else if (k == 3)
                apply(0, 0, 1, 32'h7FFF_0000 + $urandom_range(0, 65535), 0, 0, 0, 0, 0, "R3");
            else if (k == 4)
                apply(0, 0, 0, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom, $urandom, "R11");
            else
                apply(0, 0, 0, 0, 1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom, $urandom, "");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule